// File: doc/BRIEF.md
# Registered Byte-Lane Write Strobe Unit

This unit sits between the pins of a synchronous memory and its storage array. It captures the address, the write data and the active-low write controls on each rising clock edge. It turns them into one active-high write strobe per byte lane, where each lane holds eight data bits and one parity bit. A global write selects every lane. Individual lane selects count only while a shared byte-write enable is held low. When neither the global write nor the enable is low, the cycle is a read.

The array commits a write one cycle after the write is captured. During that cycle the unit drives the array's write port with the strobes, the address and the data. A read captured in the very next cycle at the same address would otherwise miss that data, so the unit forwards it. Lanes that were written return the new data and the other lanes return what the array holds. The array itself, the address sequencing and the output drivers are outside the unit.

Top module: `byte_write_ctl`

## Requirements
- R1: Address, write data and all write controls take effect only at a rising clock edge. Changes between edges do not move `memRdAddr` or `memWrEn`.
- R2: `gwN` low at a capture edge writes every lane, whatever `bweN` and `bwN` are.
- R3: With `gwN` high, `bwN` has no effect while `bweN` is high. No lane is written and the cycle is a read.
- R4: Lane i occupies data bits 9i to 9i+7 with its parity bit at 9i+8, and strobe bit i (and select bit `bwN[i]`) belongs to lane i. Lane 0 holds the lowest bits.
- R5: With `gwN` high and `bweN` low, the strobes are the bitwise inverse of `bwN`, so any subset of lanes from one to all can be written.
- R6: Controls, address and data captured at edge k appear on `memWrEn`, `memWrAddr` and `memWrData` after edge k+1, for one cycle.
- R7: `memRdAddr` shows the address captured at the most recent edge.
- R8: For a read captured directly after a write to the same address, `rdData` lanes that were written carry the new data, and the other lanes carry `memRdData`.
- R9: For a read that does not directly follow a write to the same address, `rdData` equals `memRdData`.
- R10: While `rstN` is low, no lane strobe is driven.
- R11: `rdValid` is high exactly when the cycle captured at the last edge writes no lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrIn | input | ADDR_W | Address for the current cycle |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | LANES | Per-lane write selects, active low |
| dataIn | input | 9*LANES | Write data, nine bits per lane |
| memWrEn | output | LANES | Active-high lane strobes to the array |
| memWrAddr | output | ADDR_W | Array write address |
| memWrData | output | 9*LANES | Array write data |
| memRdAddr | output | ADDR_W | Array read address |
| memRdData | input | 9*LANES | Array read data for `memRdAddr` |
| rdData | output | 9*LANES | Read data after forwarding |
| rdValid | output | 1 | Captured cycle is a read |

## Verification
The forwarding assertions assume that `memRdData` shows the array contents at `memRdAddr` in the same cycle, and that the array applies `memWrEn` at the following edge. The bench's array stand-in behaves exactly that way. The assertions also assume that the controls are stable at each rising edge. To keep within that, the bench changes inputs only at falling edges, except for the R1 scenario. That scenario changes them after a capture edge and restores them well before the next one.

// File: rtl/bwe_pkg.sv
package bwe_pkg;
  localparam int LANE_BITS = 9;

  // strobes from control to datapath
  typedef struct packed {
    logic capLoad;  // incoming cycle writes at least one lane
    logic comLoad;  // captured cycle writes at least one lane
  } dpCtl_t;
endpackage

// File: rtl/bwe_ctrl.sv
module bwe_ctrl
  import bwe_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  output logic [LANES-1:0]  memWrEn,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              rdValid,
  output logic [LANES-1:0]  passLane,
  output dpCtl_t            dpCtl
);
  localparam logic [LANES-1:0] NO_LANES = '0;

  logic              gwQ, bweQ;
  logic [LANES-1:0]  bwQ;
  logic [ADDR_W-1:0] addrQ;
  logic [LANES-1:0]  capStb;
  logic [LANES-1:0]  comStb;
  logic [ADDR_W-1:0] comAddr;
  logic              addrHit;
  logic [1:0]        warm;

  // capture stage: raw controls
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gwQ   <= 1'b1;
      bweQ  <= 1'b1;
      bwQ   <= '1;
      addrQ <= '0;
    end else begin
      gwQ   <= gwN;
      bweQ  <= bweN;
      bwQ   <= bwN;
      addrQ <= addrIn;
    end
  end

  // per-lane decode of registered controls
  for (genvar i = 0; i < LANES; i++) begin : g_decode
    assign capStb[i] = !gwQ || (!bweQ && !bwQ[i]);
  end

  // commit stage: what the array writes this cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      comStb  <= '0;
      comAddr <= '0;
    end else begin
      comStb  <= capStb;
      comAddr <= addrQ;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               warm <= 2'd0;
    else if (warm != 2'd2)   warm <= warm + 2'd1;
  end

  assign addrHit   = (comAddr == addrQ);
  assign memWrEn   = comStb;
  assign memWrAddr = comAddr;
  assign memRdAddr = addrQ;
  assign rdValid   = (capStb == NO_LANES);

  for (genvar i = 0; i < LANES; i++) begin : g_pass
    assign passLane[i] = addrHit && comStb[i];
  end

  always_comb begin
    dpCtl.capLoad = !gwN || (!bweN && !(&bwN));
    dpCtl.comLoad = (capStb != NO_LANES);
  end

  assert_global_all_R2: assert property (@(posedge clk) disable iff (!rstN)
    (warm != 2'd0 && $past(!gwN)) |-> (capStb == {LANES{1'b1}}));

  assert_read_idle_R3: assert property (@(posedge clk) disable iff (!rstN)
    (warm != 2'd0 && $past(gwN && bweN)) |-> rdValid);

  assert_subset_R5: assert property (@(posedge clk) disable iff (!rstN)
    (warm != 2'd0 && $past(gwN && !bweN)) |-> (capStb == ~$past(bwN)));

  assert_commit_delay_R6: assert property (@(posedge clk) disable iff (!rstN)
    (warm == 2'd2 && $past(!gwN, 2)) |-> (memWrEn == {LANES{1'b1}}));

  assert_reset_quiet_R10: assert property (@(posedge clk)
    !rstN |=> (memWrEn == NO_LANES));
endmodule

// File: rtl/bwe_datapath.sv
module bwe_datapath
  import bwe_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [LANES*LANE_BITS-1:0]    dataIn,
  input  dpCtl_t                        dpCtl,
  input  logic [LANES-1:0]              passLane,
  input  logic [LANES*LANE_BITS-1:0]    memRdData,
  output logic [LANES*LANE_BITS-1:0]    memWrData,
  output logic [LANES*LANE_BITS-1:0]    rdData
);
  localparam int DATA_W = LANES * LANE_BITS;

  logic [DATA_W-1:0] capData;
  logic [DATA_W-1:0] comData;

  // data registers load only for write cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capData <= '0;
      comData <= '0;
    end else begin
      if (dpCtl.capLoad) capData <= dataIn;
      if (dpCtl.comLoad) comData <= capData;
    end
  end

  assign memWrData = comData;

  // per-lane forwarding mux
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign rdData[i*LANE_BITS +: LANE_BITS] = passLane[i]
      ? comData[i*LANE_BITS +: LANE_BITS]
      : memRdData[i*LANE_BITS +: LANE_BITS];
  end

  assert_wdata_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    !dpCtl.comLoad |=> $stable(memWrData));
endmodule

// File: rtl/byte_write_ctl.sv
module byte_write_ctl
  import bwe_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int ADDR_W = 10
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [ADDR_W-1:0]          addrIn,
  input  logic                       gwN,
  input  logic                       bweN,
  input  logic [LANES-1:0]           bwN,
  input  logic [LANES*LANE_BITS-1:0] dataIn,
  output logic [LANES-1:0]           memWrEn,
  output logic [ADDR_W-1:0]          memWrAddr,
  output logic [LANES*LANE_BITS-1:0] memWrData,
  output logic [ADDR_W-1:0]          memRdAddr,
  input  logic [LANES*LANE_BITS-1:0] memRdData,
  output logic [LANES*LANE_BITS-1:0] rdData,
  output logic                       rdValid
);
  dpCtl_t           dpCtl;
  logic [LANES-1:0] passLane;

  bwe_ctrl #(.LANES(LANES), .ADDR_W(ADDR_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memRdAddr(memRdAddr), .rdValid(rdValid), .passLane(passLane),
    .dpCtl(dpCtl)
  );

  bwe_datapath #(.LANES(LANES)) i_dp (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .dpCtl(dpCtl),
    .passLane(passLane), .memRdData(memRdData), .memWrData(memWrData),
    .rdData(rdData)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assert_forward_R8: assert property (@(posedge clk) disable iff (!rstN)
      (rdValid && memWrEn[i] && memWrAddr == memRdAddr)
      |-> (rdData[i*LANE_BITS +: LANE_BITS] == memWrData[i*LANE_BITS +: LANE_BITS]));

    assert_direct_read_R9: assert property (@(posedge clk) disable iff (!rstN)
      (rdValid && !(memWrEn[i] && memWrAddr == memRdAddr))
      |-> (rdData[i*LANE_BITS +: LANE_BITS] == memRdData[i*LANE_BITS +: LANE_BITS]));
  end
endmodule

// File: tb/test_byte_write_ctl.sv
module test_byte_write_ctl;
  localparam int LANES  = 4;
  localparam int ADDR_W = 4;
  localparam int W      = LANES * 9;
  localparam int DEPTH  = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] addrIn = '0;
  logic              gwN = 1'b1, bweN = 1'b1;
  logic [LANES-1:0]  bwN = '1;
  logic [W-1:0]      dataIn = '0;
  logic [LANES-1:0]  memWrEn;
  logic [ADDR_W-1:0] memWrAddr, memRdAddr;
  logic [W-1:0]      memWrData, memRdData, rdData;
  logic              rdValid;

  logic [W-1:0] arr   [DEPTH];
  logic [W-1:0] model [DEPTH];
  int checks = 0, errors = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  byte_write_ctl #(.LANES(LANES), .ADDR_W(ADDR_W)) i_byte_write_ctl (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .gwN(gwN), .bweN(bweN),
    .bwN(bwN), .dataIn(dataIn), .memWrEn(memWrEn), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memRdAddr(memRdAddr), .memRdData(memRdData),
    .rdData(rdData), .rdValid(rdValid)
  );

  // array stand-in: combinational read, commit at edge
  assign memRdData = arr[memRdAddr];
  always @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (memWrEn[i]) arr[memWrAddr][i*9 +: 9] <= memWrData[i*9 +: 9];
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // drive one cycle at a falling edge; return at the next falling edge
  task automatic doOp(input logic g, input logic be, input logic [LANES-1:0] b,
                      input logic [ADDR_W-1:0] a, input logic [W-1:0] d);
    logic [LANES-1:0] we;
    gwN = g; bweN = be; bwN = b; addrIn = a; dataIn = d;
    we = !g ? '1 : (!be ? ~b : '0);
    for (int i = 0; i < LANES; i++)
      if (we[i]) model[a][i*9 +: 9] = d[i*9 +: 9];
    @(negedge clk);
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a);
    doOp(1'b1, 1'b1, '1, a, '0);
  endtask

  task automatic t_reset;
    rstN = 0;
    repeat (3) @(negedge clk);
    chk("R10 strobes in reset", 64'(memWrEn), 64'(0));
    chk("R11 rdValid in reset", 64'(rdValid), 64'(1));
    rstN = 1;
    @(negedge clk);
    chk("R10 strobes after reset", 64'(memWrEn), 64'(0));
  endtask

  task automatic t_global;
    logic [W-1:0] d = 36'h1_2345_6789;
    doOp(1'b0, 1'b1, '1, 4'd2, d);
    chk("R11 rdValid low on write", 64'(rdValid), 64'(0));
    chk("R7 read address", 64'(memRdAddr), 64'(2));
    rd(4'd2);
    chk("R2 all lanes strobed", 64'(memWrEn), 64'(4'hF));
    chk("R6 write address", 64'(memWrAddr), 64'(2));
    chk("R6 write data", 64'(memWrData), 64'(d));
    chk("R8 full forward", 64'(rdData), 64'(model[2]));
    chk("R11 rdValid on read", 64'(rdValid), 64'(1));
  endtask

  task automatic t_gwOverride;
    doOp(1'b0, 1'b0, 4'b1110, 4'd1, 36'hA_BCDE_F012);
    rd(4'd1);
    chk("R2 overrides selects", 64'(memWrEn), 64'(4'hF));
    chk("R8 forward after override", 64'(rdData), 64'(model[1]));
  endtask

  task automatic t_noEnable;
    logic [W-1:0] old = model[3];
    doOp(1'b1, 1'b1, 4'b0000, 4'd3, 36'hF_FFFF_FFFF);
    chk("R3 selects ignored, read cycle", 64'(rdValid), 64'(1));
    rd(4'd3);
    chk("R3 no strobes", 64'(memWrEn), 64'(0));
    chk("R3 contents unchanged", 64'(rdData), 64'(old));
  endtask

  task automatic t_subset;
    doOp(1'b1, 1'b0, 4'b1010, 4'd5, 36'h5_5AA5_A55A);
    rd(4'd5);
    chk("R5 strobes invert selects", 64'(memWrEn), 64'(4'b0101));
    chk("R8 partial forward", 64'(rdData), 64'(model[5]));
    rd(4'd5);
    chk("R6 strobes last one cycle", 64'(memWrEn), 64'(0));
    chk("R9 committed subset", 64'(rdData), 64'(model[5]));
  endtask

  task automatic t_laneMap;
    logic [W-1:0] old = model[6];
    logic [W-1:0] d = 36'h0_0003_FE00;
    doOp(1'b1, 1'b0, 4'b1101, 4'd6, d);
    rd(4'd6);
    chk("R4 lane1 strobe bit", 64'(memWrEn), 64'(4'b0010));
    chk("R4 lane1 bits 17:9", 64'(rdData[17:9]), 64'(d[17:9]));
    chk("R4 lane0 kept", 64'(rdData[8:0]), 64'(old[8:0]));
    chk("R4 lanes 3..2 kept", 64'(rdData[35:18]), 64'(old[35:18]));
  endtask

  task automatic t_otherAddr;
    doOp(1'b0, 1'b1, '1, 4'd7, 36'h7_7777_7777);
    rd(4'd8);
    chk("R9 other address", 64'(rdData), 64'(model[8]));
    rd(4'd7);
    chk("R9 later read", 64'(rdData), 64'(model[7]));
  endtask

  task automatic t_backToBack;
    doOp(1'b1, 1'b0, 4'b1110, 4'd9, 36'h1_1111_1111);
    doOp(1'b1, 1'b0, 4'b0111, 4'd9, 36'h2_2222_2222);
    rd(4'd9);
    chk("R8 back-to-back merge", 64'(rdData), 64'(model[9]));
  endtask

  task automatic t_between;
    rd(4'd4);
    gwN = 1'b0; addrIn = 4'd11;
    #5;
    chk("R1 read address held", 64'(memRdAddr), 64'(4));
    chk("R1 strobes held", 64'(memWrEn), 64'(0));
    chk("R1 capture not disturbed", 64'(rdValid), 64'(1));
    gwN = 1'b1; addrIn = 4'd4;
    @(negedge clk);
    chk("R7 read address after edge", 64'(memRdAddr), 64'(4));
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) begin
      arr[a]   = 36'(64'h9_ABCD_EF01 * (a + 3));
      model[a] = arr[a];
    end
    @(negedge clk);
    t_reset();
    t_global();
    t_gwOverride();
    t_noEnable();
    t_subset();
    t_laneMap();
    t_otherAddr();
    t_backToBack();
    t_between();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule